// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block owns the 32-bit program counter of a simple non-pipelined core. It presents the counter as the read address of an instruction memory that answers one cycle after the request. The returned word is then handed to decode in the following cycle. While decode looks at that word, the block works out the next counter value and loads it at the end of the cycle. The next value is either the sequential successor or a PC-relative branch target.

The branch target is built from the low 16 bits of the instruction. That field is sign-extended, shifted left by two and added to PC+4, so every target is word-aligned and reaches roughly ±128 KiB. Decode supplies a branch-enable flag and two register operands. The branch is taken only when the flag is high and the operands are equal.

Fetching runs as an issue cycle followed by a response cycle. A fetch-enable input gates the issue cycle only, and a request that has been issued always completes.

Top module: `ifetch_unit`

## Requirements
- R1: While rst_ni is low the program counter is 0x00000000 and instr_valid_o is 0. The first request after reset uses address 0, and reset takes effect without a clock edge.
- R2: In an issue cycle with fetch_en_i high, imem_req_o is 1 and imem_addr_o equals the current program counter.
- R3: The cycle after a request is a response cycle, whatever fetch_en_i is then. In it instr_valid_o is 1 and instr_o equals imem_rdata_i. In every other cycle instr_valid_o is 0 and instr_o is 0.
- R4: After a response cycle that is not taken, the program counter is the old value plus 4.
- R5: After a taken response cycle, the program counter is PC + 4 + (sign-extended instr bits [15:0] shifted left by 2), modulo 2^32.
- R6: With branch_en_i low, nothing is taken, even when the operands are equal. Operands that differ in any bit, the MSB included, also give not-taken.
- R7: In an issue cycle with fetch_en_i low, no request is made, instr_valid_o stays 0 in the next cycle, and the program counter holds its value.
- R8: taken_o is 1 only in a response cycle where branch_en_i is 1 and rs_a_i equals rs_b_i.
- R9: imem_addr_o[1:0] is always 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_en_i | input | 1 | Allows a new fetch request in the issue cycle |
| imem_req_o | output | 1 | Instruction memory read strobe |
| imem_addr_o | output | 32 | Instruction memory address (program counter) |
| imem_rdata_i | input | 32 | Memory read data, valid the cycle after a request |
| instr_valid_o | output | 1 | Forwarded instruction is valid |
| instr_o | output | 32 | Instruction forwarded to decode (zero when not valid) |
| branch_en_i | input | 1 | Decode flags the forwarded word as a conditional branch |
| rs_a_i | input | 32 | First compared register operand |
| rs_b_i | input | 32 | Second compared register operand |
| taken_o | output | 1 | Branch taken in this response cycle |

## Verification
The bench walks a table of fetched words. The entries include equal operands with positive, negative-one, maximum positive and minimum negative offsets. One entry has the minimum negative offset from a small PC, so the target wraps below zero. Another pair of entries keeps equal operands but with the branch flag low, and differs the operands in the sign bit only. These separate the sequential path from the taken path, confirm that the offset is added to PC+4 rather than PC, and exercise full 32-bit equality and the sign extension. Within the table, fetch_en_i is dropped during some response cycles to show that an issued fetch still completes. Directed tests then hold fetch_en_i low and reset mid-run.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  typedef enum logic {
    PH_ISSUE = 1'b0,
    PH_RESP  = 1'b1
  } phase_e;
endpackage

// File: rtl/ifu_seq_ctrl.sv
module ifu_seq_ctrl
  import ifu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fetch_en_i,
  output logic req_o,
  output logic resp_o
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_ISSUE: if (fetch_en_i) ph_d = PH_RESP;
      PH_RESP:  ph_d = PH_ISSUE;
      default:  ph_d = PH_ISSUE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_ISSUE;
    else         ph_q <= ph_d;
  end

  assign req_o  = (ph_q == PH_ISSUE) && fetch_en_i;
  assign resp_o = (ph_q == PH_RESP);
endmodule

// File: rtl/ifu_target_gen.sv
module ifu_target_gen #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int SHIFT = 2
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  output logic [XLEN-1:0] seq_o,
  output logic [XLEN-1:0] tgt_o
);
  localparam int EXT_W = XLEN - OFS_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << SHIFT;

  logic [XLEN-1:0] disp_ext;

  assign disp_ext = {{EXT_W{instr_i[OFS_W-1]}}, instr_i[OFS_W-1:0]};
  assign seq_o    = pc_i + STEP;
  // target is relative to the sequential successor, not the fetch address
  assign tgt_o    = seq_o + (disp_ext << SHIFT);
endmodule

// File: rtl/ifu_branch_cmp.sv
module ifu_branch_cmp #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  logic            en_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            taken_o
);
  localparam int LANES = (XLEN + LANE_W - 1) / LANE_W;
  localparam int PAD_W = LANES * LANE_W;

  logic [PAD_W-1:0] a_pad, b_pad;
  logic [LANES-1:0] lane_eq;

  assign a_pad = PAD_W'(a_i);
  assign b_pad = PAD_W'(b_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (a_pad[g*LANE_W +: LANE_W] == b_pad[g*LANE_W +: LANE_W]);
  end

  assign taken_o = en_i && (&lane_eq);
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit #(
  parameter int              XLEN     = 32,
  parameter int              OFS_W    = 16,
  parameter int              SHIFT    = 2,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_en_i,
  output logic            imem_req_o,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [XLEN-1:0] imem_rdata_i,
  output logic            instr_valid_o,
  output logic [XLEN-1:0] instr_o,
  input  logic            branch_en_i,
  input  logic [XLEN-1:0] rs_a_i,
  input  logic [XLEN-1:0] rs_b_i,
  output logic            taken_o
);
  logic [XLEN-1:0] pc_q, pc_seq, pc_tgt;
  logic            resp, br_hit;

  ifu_seq_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fetch_en_i (fetch_en_i),
    .req_o      (imem_req_o),
    .resp_o     (resp)
  );

  ifu_target_gen #(.XLEN(XLEN), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_tgt (
    .pc_i    (pc_q),
    .instr_i (imem_rdata_i),
    .seq_o   (pc_seq),
    .tgt_o   (pc_tgt)
  );

  ifu_branch_cmp #(.XLEN(XLEN)) u_cmp (
    .en_i    (branch_en_i & resp),
    .a_i     (rs_a_i),
    .b_i     (rs_b_i),
    .taken_o (br_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pc_q <= RESET_PC;
    else if (resp) pc_q <= br_hit ? pc_tgt : pc_seq;
  end

  assign imem_addr_o   = pc_q;
  assign instr_valid_o = resp;
  assign instr_o       = resp ? imem_rdata_i : '0;
  assign taken_o       = br_hit;
endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fetch_en_i,
  input logic            imem_req_o,
  input logic [XLEN-1:0] imem_addr_o,
  input logic            instr_valid_o,
  input logic            taken_o
);
  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_addr_o[1:0] == 2'b00);  // R9
  AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o |-> fetch_en_i);  // R2
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o |=> instr_valid_o);  // R3
  AST_NO_DOUBLE_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |=> !instr_valid_o);  // R3
  AST_IDLE_HOLDS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imem_req_o && !instr_valid_o) |=> ($stable(imem_addr_o) && !instr_valid_o));  // R7
  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && !taken_o) |=> (imem_addr_o == $past(imem_addr_o) + 32'd4));  // R4
  AST_TAKEN_IN_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> instr_valid_o);  // R8
endmodule

bind ifetch_unit ifetch_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_en_i    (fetch_en_i),
  .imem_req_o    (imem_req_o),
  .imem_addr_o   (imem_addr_o),
  .instr_valid_o (instr_valid_o),
  .taken_o       (taken_o)
);

// File: tb/sim_ifetch_unit.sv
`timescale 1ns/1ps
module sim_ifetch_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_en_i = 1'b0;
  logic        imem_req_o;
  logic [31:0] imem_addr_o;
  logic [31:0] imem_rdata_i = '0;
  logic        instr_valid_o;
  logic [31:0] instr_o;
  logic        branch_en_i = 1'b0;
  logic [31:0] rs_a_i = '0;
  logic [31:0] rs_b_i = '0;
  logic        taken_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] mpc;

  always #4 clk_i = ~clk_i;

  ifetch_unit u0 (.*);

  typedef struct packed {
    logic [31:0] word;
    logic        en;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h1000_0003, 1'b1, 32'h0000_0005, 32'h0000_0005},
    '{32'h2000_FFFF, 1'b1, 32'h0000_0000, 32'h0000_0000},
    '{32'h3000_0004, 1'b0, 32'h0000_0007, 32'h0000_0007},
    '{32'h4000_0002, 1'b1, 32'h0000_0001, 32'h0000_0002},
    '{32'h5000_7FFF, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{32'h6000_8000, 1'b1, 32'h8000_0000, 32'h0000_0000},
    '{32'h7000_8000, 1'b1, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    '{32'h8000_8000, 1'b1, 32'h0000_0000, 32'h0000_0000},
    '{32'h9000_0000, 1'b1, 32'h1234_5678, 32'h1234_5678}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fetch_one(input vec_t v, input bit en_in_resp);
    logic        exp_t;
    logic [31:0] disp;
    @(negedge clk_i);
    fetch_en_i = 1'b1;
    #1;
    chk(imem_req_o === 1'b1, "R2 req", 32'(imem_req_o), 32'd1);
    chk(imem_addr_o === mpc, "R2 addr", imem_addr_o, mpc);
    chk(imem_addr_o[1:0] === 2'b00, "R9 align", imem_addr_o, mpc);
    @(negedge clk_i);
    fetch_en_i   = en_in_resp;
    imem_rdata_i = v.word;
    branch_en_i  = v.en;
    rs_a_i       = v.a;
    rs_b_i       = v.b;
    #1;
    exp_t = v.en && (v.a == v.b);
    disp  = {{14{v.word[15]}}, v.word[15:0], 2'b00};
    chk(instr_valid_o === 1'b1, "R3 valid", 32'(instr_valid_o), 32'd1);
    chk(instr_o === v.word, "R3 instr", instr_o, v.word);
    chk(taken_o === exp_t, exp_t ? "R8 taken" : "R6 not taken", 32'(taken_o), 32'(exp_t));
    mpc = mpc + 32'd4 + (exp_t ? disp : 32'd0);
    @(negedge clk_i);
    fetch_en_i  = 1'b0;
    branch_en_i = 1'b0;
    #1;
    chk(imem_addr_o === mpc, exp_t ? "R5 target" : "R4 next", imem_addr_o, mpc);
    chk(instr_valid_o === 1'b0 && instr_o === 32'd0, "R3 idle", instr_o, 32'd0);
  endtask

  initial begin
    mpc = 32'd0;
    repeat (3) @(negedge clk_i);
    #1;
    chk(imem_addr_o === 32'd0, "R1 reset pc", imem_addr_o, 32'd0);
    chk(instr_valid_o === 1'b0, "R1 reset valid", 32'(instr_valid_o), 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) fetch_one(VECS[i], i[0]);

    // R7: fetch disabled, PC holds and nothing is forwarded
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      #1;
      chk(imem_req_o === 1'b0, "R7 no req", 32'(imem_req_o), 32'd0);
      chk(instr_valid_o === 1'b0, "R7 no valid", 32'(instr_valid_o), 32'd0);
      chk(imem_addr_o === mpc, "R7 hold", imem_addr_o, mpc);
    end

    // R1: asynchronous reset mid-run returns PC to 0
    @(negedge clk_i);
    #2;
    rst_ni = 1'b0;
    #1;
    chk(imem_addr_o === 32'd0, "R1 async reset", imem_addr_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    mpc = 32'd0;
    fetch_one(VECS[0], 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule